// File: doc/BRIEF.md
# Sleep Mode and Wake-up Sequencer

This block decides when a small microcontroller core may stop, which clock domains keep toggling while it is stopped, and how it is brought back. Software programs a sleep-permit bit and a three-bit mode field. The core then issues a one-cycle sleep strobe. If the permit bit is set at that moment, the sequencer halts the core and applies the clock-gating and oscillator pattern of the chosen mode. Otherwise the strobe has no effect.

While asleep, the sequencer watches a set of wake requests. Which requests it honours depends on the mode. A request it honours starts the return. First comes an oscillator start-up wait, which is shorter when the oscillator was never stopped. Then a fixed four-cycle halt follows. Finally a one-cycle resume pulse tells the core to take the pending interrupt and continue after the sleep instruction. An asynchronous reset at any time returns the block to the running state at once, with no resume pulse, so the core restarts from its reset vector. The sequencer has no output that could clear registers or memory.

Top module: `slp_seq`

## Requirements
- R1: After reset, and whenever the core runs, `halt` is 0, all four `clk_en` bits are 1, `osc_run` is 1 and `resume` is 0.
- R2: A `slp_strobe` seen while `sleep_en` is 0 is ignored, and so is any strobe that arrives while `halt` is 1. In both cases `halt` stays as it was.
- R3: A `slp_strobe` with `sleep_en` at 1 while running sets `halt` in the next cycle. From then on the CPU clock enable (`clk_en[0]`) stays 0 until the core runs again.
- R4: `mode_sel` encodes 000 Idle, 001 ADC-quiet, 010 Power-off, 011 Power-keep, 110 Standby and 111 Extended Standby. The codes 100 and 101 act as Idle. While asleep, `clk_en` = {async, adc, io, cpu} is 1110 in Idle, 1100 in ADC-quiet, 0000 in Power-off, 1000 in Power-keep, 0000 in Standby and 1000 in Extended Standby. `osc_run` is 0 only in Power-off and Power-keep.
- R5: A level request on any external pin (`ext_lvl`) wakes every mode. `adc_irq` wakes only Idle and ADC-quiet. `io_irq` wakes only Idle.
- R6: `tmr_irq` wakes Idle in all cases. In ADC-quiet, Power-keep and Extended Standby it wakes only when `tmr_async` is 1. It never wakes Power-off or Standby.
- R7: An edge request on an external pin (`ext_edge`) wakes only Idle.
- R8: From the clock edge that samples a wake request, `halt` stays 1 for the start-up count plus four cycles. The start-up count is `COLD_CYC` for Power-off and Power-keep, and `WARM_CYC` for all other modes.
- R9: `resume` is high for exactly one cycle, the first cycle with `halt` at 0 after a wake-up. It then falls.
- R10: Pulling `rst_n` low during sleep or during the wake sequence returns the outputs to the running state of R1 without a `resume` pulse.
- R11: During the start-up wait `osc_run` is 1 and `clk_en` keeps the sleep pattern. During the four-cycle halt `clk_en` is 1110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_en | input | 1 | Sleep-permit bit from the control register |
| mode_sel | input | 3 | Sleep mode field |
| slp_strobe | input | 1 | One-cycle sleep-instruction strobe from the core |
| ext_lvl | input | NUM_EXT | Enabled external pins whose level condition is active |
| ext_edge | input | NUM_EXT | Enabled external pins that saw an edge |
| tmr_irq | input | 1 | Asynchronous-capable timer interrupt request |
| tmr_async | input | 1 | Timer runs from its own asynchronous clock |
| adc_irq | input | 1 | Converter-complete interrupt request |
| io_irq | input | 1 | Any other peripheral interrupt request |
| halt | output | 1 | Core is held stopped |
| clk_en | output | 4 | Domain clock enables {async, adc, io, cpu} |
| osc_run | output | 1 | Main oscillator allowed to run |
| resume | output | 1 | One-cycle pulse: core may proceed after wake-up |

## Verification
The assertions check on every cycle that ignored strobes leave `halt` low and valid strobes raise it with the CPU clock gated. They also check that the oscillator only stops with the core halted and the io and converter domains gated, that a running core sees every clock, that `resume` is a single pulse on the fall of `halt`, and that each wake-up spans exactly the latched start-up count plus four cycles. Only the bench scenarios show that the mode table is correct. That covers which clock pattern each code selects, that reserved codes behave as Idle, that each wake source is honoured or refused per mode, and that the timer depends on its asynchronous flag. The bench also shows that a reset during sleep comes back without a resume pulse.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [2:0] {
    MD_IDLE  = 3'b000,
    MD_ADCNR = 3'b001,
    MD_PDOWN = 3'b010,
    MD_PSAVE = 3'b011,
    MD_STBY  = 3'b110,
    MD_XSTBY = 3'b111
  } slp_mode_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_SLEEP,
    ST_START,
    ST_HALT
  } seq_st_e;

  localparam int DOM_N    = 4;  // {async, adc, io, cpu}
  localparam int SRC_N    = 5;  // {io, adc, tmr, edge, lvl}
  localparam int HALT_CYC = 4;

  localparam int SRC_LVL  = 0;
  localparam int SRC_EDGE = 1;
  localparam int SRC_TMR  = 2;
  localparam int SRC_ADC  = 3;
  localparam int SRC_IO   = 4;

  // Reserved field codes fall back to Idle.
  function automatic slp_mode_e decode_mode(input logic [2:0] f);
    case (f)
      3'b001:  return MD_ADCNR;
      3'b010:  return MD_PDOWN;
      3'b011:  return MD_PSAVE;
      3'b110:  return MD_STBY;
      3'b111:  return MD_XSTBY;
      default: return MD_IDLE;
    endcase
  endfunction

  function automatic logic [DOM_N-1:0] dom_mask(input slp_mode_e m);
    case (m)
      MD_IDLE:  return 4'b1110;
      MD_ADCNR: return 4'b1100;
      MD_PSAVE: return 4'b1000;
      MD_XSTBY: return 4'b1000;
      default:  return 4'b0000;
    endcase
  endfunction

  function automatic logic osc_keep(input slp_mode_e m);
    return !(m == MD_PDOWN || m == MD_PSAVE);
  endfunction

  function automatic logic [SRC_N-1:0] wake_mask(input slp_mode_e m);
    case (m)
      MD_IDLE:  return 5'b11111;
      MD_ADCNR: return 5'b01101;
      MD_PSAVE: return 5'b00101;
      MD_XSTBY: return 5'b00101;
      default:  return 5'b00001;
    endcase
  endfunction

endpackage

// File: rtl/slp_wake_sel.sv
module slp_wake_sel
  import slp_pkg::*;
#(
  parameter int NUM_EXT = 2
) (
  input  slp_mode_e          mode,
  input  logic               armed,
  input  logic [NUM_EXT-1:0] ext_lvl,
  input  logic [NUM_EXT-1:0] ext_edge,
  input  logic               tmr_irq,
  input  logic               tmr_async,
  input  logic               adc_irq,
  input  logic               io_irq,
  output logic [SRC_N-1:0]   src_vec,
  output logic               wake
);

  logic tmr_ok;

  // In Idle the timer clock is alive anyway; elsewhere only its own clock helps.
  assign tmr_ok = tmr_irq && (tmr_async || mode == MD_IDLE);

  always_comb begin
    src_vec           = '0;
    src_vec[SRC_LVL]  = |ext_lvl;
    src_vec[SRC_EDGE] = |ext_edge;
    src_vec[SRC_TMR]  = tmr_ok;
    src_vec[SRC_ADC]  = adc_irq;
    src_vec[SRC_IO]   = io_irq;
  end

  assign wake = armed && |(src_vec & wake_mask(mode));

endmodule

// File: rtl/slp_dly_cnt.sv
module slp_dly_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
#(
  parameter int NUM_EXT  = 2,
  parameter int COLD_CYC = 16,
  parameter int WARM_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_en,
  input  logic [2:0]         mode_sel,
  input  logic               slp_strobe,
  input  logic [NUM_EXT-1:0] ext_lvl,
  input  logic [NUM_EXT-1:0] ext_edge,
  input  logic               tmr_irq,
  input  logic               tmr_async,
  input  logic               adc_irq,
  input  logic               io_irq,
  output logic               halt,
  output logic [3:0]         clk_en,
  output logic               osc_run,
  output logic               resume
);

  localparam int CW_RAW = $clog2(COLD_CYC + 1);
  localparam int CW     = (CW_RAW < 3) ? 3 : CW_RAW;

  seq_st_e        state_q;
  slp_mode_e      mode_q;
  logic [CW-1:0]  span_q;
  logic           resume_q;

  // Named events shared with the checker
  logic           enter_evt;
  logic           wake_evt;
  logic           start_done;
  logic           halt_done;
  logic           wake_hit;
  logic           cnt_zero;
  logic           cnt_load;
  logic [CW-1:0]  cnt_val;
  logic [CW-1:0]  span_next;
  logic [SRC_N-1:0] src_vec;

  slp_wake_sel #(.NUM_EXT(NUM_EXT)) i_wake (
    .mode      (mode_q),
    .armed     (state_q == ST_SLEEP),
    .ext_lvl   (ext_lvl),
    .ext_edge  (ext_edge),
    .tmr_irq   (tmr_irq),
    .tmr_async (tmr_async),
    .adc_irq   (adc_irq),
    .io_irq    (io_irq),
    .src_vec   (src_vec),
    .wake      (wake_hit)
  );

  assign enter_evt  = (state_q == ST_RUN) && slp_strobe && sleep_en;
  assign wake_evt   = wake_hit;
  assign start_done = (state_q == ST_START) && cnt_zero;
  assign halt_done  = (state_q == ST_HALT) && cnt_zero;

  assign span_next  = osc_keep(mode_q) ? CW'(WARM_CYC) : CW'(COLD_CYC);
  assign cnt_load   = wake_evt || start_done;
  assign cnt_val    = wake_evt ? (span_next - 1'b1) : CW'(HALT_CYC - 1);

  slp_dly_cnt #(.W(CW)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      mode_q   <= MD_IDLE;
      span_q   <= '0;
      resume_q <= 1'b0;
    end else begin
      resume_q <= halt_done;
      case (state_q)
        ST_RUN: if (enter_evt) begin
          state_q <= ST_SLEEP;
          mode_q  <= decode_mode(mode_sel);
        end
        ST_SLEEP: if (wake_evt) begin
          state_q <= ST_START;
          span_q  <= span_next;
        end
        ST_START: if (start_done) state_q <= ST_HALT;
        default:  if (halt_done)  state_q <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_RUN:   begin clk_en = 4'b1111;         osc_run = 1'b1;             end
      ST_SLEEP: begin clk_en = dom_mask(mode_q); osc_run = osc_keep(mode_q); end
      ST_START: begin clk_en = dom_mask(mode_q); osc_run = 1'b1;             end
      default:  begin clk_en = 4'b1110;         osc_run = 1'b1;             end
    endcase
  end

  assign halt   = (state_q != ST_RUN);
  assign resume = resume_q;

endmodule

// File: rtl/slp_seq_chk.sv
module slp_seq_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep_en,
  input logic          slp_strobe,
  input logic          halt,
  input logic [3:0]    clk_en,
  input logic          osc_run,
  input logic          resume,
  input logic          wake_evt,
  input logic [CW-1:0] span_q
);

  logic [CW+2:0] wcnt;

  // Cycles since the wake sample, advanced while the core stays halted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wcnt <= '0;
    else if (wake_evt) wcnt <= 1;
    else if (halt)     wcnt <= wcnt + 1'b1;
  end

  AST_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && slp_strobe && !sleep_en) |=> !halt); // R2

  AST_ENTER_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && slp_strobe && sleep_en) |=> (halt && !clk_en[0])); // R3

  AST_OSC_STOP_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run |-> (halt && !clk_en[1] && !clk_en[2])); // R4

  AST_RUN_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !halt |-> (clk_en == 4'b1111 && osc_run)); // R1

  AST_WAKE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> ($past(wcnt) == ({3'b000, $past(span_q)} + 4))); // R8

  AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume); // R9

  AST_RESUME_ON_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (!halt && $past(halt))); // R9

endmodule

bind slp_seq slp_seq_chk #(.CW(CW)) i_slp_seq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sleep_en   (sleep_en),
  .slp_strobe (slp_strobe),
  .halt       (halt),
  .clk_en     (clk_en),
  .osc_run    (osc_run),
  .resume     (resume),
  .wake_evt   (wake_evt),
  .span_q     (span_q)
);

// File: tb/test_slp_seq.sv
`timescale 1ns/1ps
module test_slp_seq;

  localparam int COLD = 16;
  localparam int WARM = 2;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       sleep_en = 0;
  logic [2:0] mode_sel = 0;
  logic       slp_strobe = 0;
  logic [1:0] ext_lvl = 0;
  logic [1:0] ext_edge = 0;
  logic       tmr_irq = 0, tmr_async = 0, adc_irq = 0, io_irq = 0;
  logic       halt, osc_run, resume;
  logic [3:0] clk_en;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  slp_seq #(.NUM_EXT(2), .COLD_CYC(COLD), .WARM_CYC(WARM)) i_slp_seq (
    .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .mode_sel(mode_sel),
    .slp_strobe(slp_strobe), .ext_lvl(ext_lvl), .ext_edge(ext_edge),
    .tmr_irq(tmr_irq), .tmr_async(tmr_async), .adc_irq(adc_irq),
    .io_irq(io_irq), .halt(halt), .clk_en(clk_en), .osc_run(osc_run),
    .resume(resume)
  );

  // ---- expected-value model, built from the requirement tables ----
  function automatic int m_idx(input logic [2:0] f);
    case (f)
      3'b001: return 1;  3'b010: return 2;  3'b011: return 3;
      3'b110: return 4;  3'b111: return 5;  default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] x_dom(input logic [2:0] f);
    case (m_idx(f))
      0: return 4'b1110;  1: return 4'b1100;  3: return 4'b1000;
      5: return 4'b1000;  default: return 4'b0000;
    endcase
  endfunction

  function automatic logic x_osc(input logic [2:0] f);
    return !(m_idx(f) == 2 || m_idx(f) == 3);
  endfunction

  function automatic int x_span(input logic [2:0] f);
    return x_osc(f) ? WARM : COLD;
  endfunction

  // src: 0 level, 1 edge, 2 timer, 3 adc, 4 io
  function automatic logic x_wake(input logic [2:0] f, input int src, input logic async_on);
    int i = m_idx(f);
    case (src)
      0: return 1'b1;
      1: return i == 0;
      2: return (i == 0) || ((i == 1 || i == 3 || i == 5) && async_on);
      3: return i == 0 || i == 1;
      default: return i == 0;
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_src(input int src, input logic v);
    case (src)
      0: ext_lvl  = v ? 2'b10 : 2'b00;
      1: ext_edge = v ? 2'b01 : 2'b00;
      2: tmr_irq  = v;
      3: adc_irq  = v;
      default: io_irq = v;
    endcase
  endtask

  task automatic go_sleep(input logic [2:0] f);
    @(negedge clk);
    sleep_en = 1; mode_sel = f; slp_strobe = 1;
    @(negedge clk);
    slp_strobe = 0; sleep_en = 0;
    chk(halt == 1, "R3", "halt after strobe", int'(halt), 1);
    chk(clk_en == x_dom(f), "R4", "sleep clk_en", int'(clk_en), int'(x_dom(f)));
    chk(osc_run == x_osc(f), "R4", "sleep osc_run", int'(osc_run), int'(x_osc(f)));
  endtask

  // Source raised at negedge; resume is expected at negedge span+5 after that.
  task automatic wake_and_time(input logic [2:0] f, input int src, input logic strobe_mid);
    int k;
    int span = x_span(f);
    set_src(src, 1);
    @(negedge clk);
    set_src(src, 0);
    k = 1;
    chk(osc_run == 1 && clk_en == x_dom(f), "R11", "start-up phase enables",
        int'({osc_run, clk_en}), int'({1'b1, x_dom(f)}));
    if (strobe_mid) begin sleep_en = 1; slp_strobe = 1; end
    while (!resume && k < 200) begin
      @(negedge clk);
      slp_strobe = 0; sleep_en = 0;
      k++;
      if (k == span + 2)
        chk(clk_en == 4'b1110 && osc_run, "R11", "halt phase enables",
            int'(clk_en), 14);
    end
    chk(k == span + 5, "R8", "wake span", k, span + 5);
    chk(halt == 0, "R9", "halt low with resume", int'(halt), 0);
    @(negedge clk);
    chk(resume == 0 && halt == 0, "R9", "resume single pulse",
        int'({resume, halt}), 0);
  endtask

  task automatic hold_no_wake(input int src, input string req);
    set_src(src, 1);
    repeat (4) @(negedge clk);
    chk(halt == 1 && resume == 0, req, "refused source keeps sleep",
        int'({halt, resume}), 2);
    set_src(src, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(halt == 0 && clk_en == 4'b1111 && osc_run && !resume, "R1", "in reset",
        int'({halt, clk_en, osc_run, resume}), 6'b011110 >> 0);
    rst_n = 1;
    @(negedge clk);
    chk(halt == 0 && clk_en == 4'b1111 && osc_run && !resume, "R1", "after reset",
        int'({halt, clk_en, osc_run, resume}), 30);

    // R2: strobe with permit bit low
    sleep_en = 0; mode_sel = 3'b010; slp_strobe = 1;
    @(negedge clk); slp_strobe = 0;
    repeat (2) @(negedge clk);
    chk(halt == 0 && clk_en == 4'b1111, "R2", "strobe without permit", int'(halt), 0);

    // every field code, woken by a level request: R4 table and R8 span
    for (int f = 0; f < 8; f++) begin
      go_sleep(3'(f));
      wake_and_time(3'(f), 0, 1'b0);
    end

    // R7: edge refused in Standby, honoured in Idle
    go_sleep(3'b110); hold_no_wake(1, "R7");
    wake_and_time(3'b110, 0, 1'b0);
    go_sleep(3'b000); wake_and_time(3'b000, 1, 1'b0);

    // R6: timer in Power-keep depends on its asynchronous flag
    tmr_async = 0;
    go_sleep(3'b011); hold_no_wake(2, "R6");
    tmr_async = 1;
    wake_and_time(3'b011, 2, 1'b0);
    go_sleep(3'b010); hold_no_wake(2, "R6");
    wake_and_time(3'b010, 0, 1'b0);
    tmr_async = 0;

    // R5: converter request refused in Power-off, io honoured in Idle
    go_sleep(3'b010); hold_no_wake(3, "R5");
    wake_and_time(3'b010, 0, 1'b0);
    go_sleep(3'b101); wake_and_time(3'b101, 4, 1'b0);

    // R2: strobe during start-up wait has no effect
    go_sleep(3'b111); wake_and_time(3'b111, 0, 1'b1);
    @(negedge clk);
    chk(halt == 0, "R2", "strobe while halted ignored", int'(halt), 0);

    // R10: reset while asleep
    go_sleep(3'b010);
    rst_n = 0;
    #1;
    chk(halt == 0 && clk_en == 4'b1111 && osc_run && !resume, "R10", "reset in sleep",
        int'({halt, clk_en, osc_run, resume}), 30);
    @(negedge clk); rst_n = 1;
    repeat (3) begin
      @(negedge clk);
      chk(resume == 0 && halt == 0, "R10", "no resume after reset",
          int'({resume, halt}), 0);
    end

    // R10: reset during start-up wait
    go_sleep(3'b011);
    ext_lvl = 2'b01; @(negedge clk); ext_lvl = 0;
    @(negedge clk); rst_n = 0; #1;
    chk(halt == 0 && !resume, "R10", "reset in start-up", int'(halt), 0);
    @(negedge clk); rst_n = 1;
    repeat (20) begin
      @(negedge clk);
      chk(resume == 0, "R10", "start-up abandoned", int'(resume), 0);
    end

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [2:0] f = 3'($urandom % 8);
      int src = int'($urandom % 5);
      tmr_async = 1'($urandom % 2);
      go_sleep(f);
      if (x_wake(f, src, tmr_async)) begin
        wake_and_time(f, src, 1'b0);
      end else begin
        hold_no_wake(src, src == 1 ? "R7" : (src == 2 ? "R6" : "R5"));
        wake_and_time(f, 0, 1'b0);
      end
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule